// File: doc/BRIEF.md
# Linked-List DMA Channel

This block is a single DMA channel that copies 32-bit words between a host memory port and a device port. In single-block mode it uses the host address, device address and byte count that software loads into its register file. In chained mode it reads descriptors from host memory, one after another. Each descriptor is four words. The channel copies that descriptor's data and then follows the link word until it finds a descriptor marked as the last one.

Software loads the configuration while the channel is idle. It starts a transfer by writing enable and start together to the control/status register, and then either polls or waits for the interrupt. Completion is shown by sticky status bits that software clears by writing ones. An abort stops the transfer without raising any completion status. Software detects it by reading enable back as clear.

Top module: `dma_chain_ch`

## Requirements
- R1: After reset every register reads zero, `irq` is low and neither `mem_req` nor `dev_req` is asserted.
- R2: Register byte offsets are 0x00 host address, 0x04 device address, 0x08 byte count, 0x0C descriptor pointer, 0x10 mode and 0x14 control/status. Control/status bits are: bit0 enable, bit1 start (it reads back as "transfer active"), bit2 abort, bit3 transfer done and bit4 descriptor done. A transfer starts only when bits 0 and 1 are both written as one while the channel is idle.
- R3: With mode bit0 = 0 (single block), the channel copies ceil(count/4) words. After each word both addresses advance by 4 and the count falls by 4, ending at zero. Mode bit2 = 1 copies host to device; bit2 = 0 copies device to host.
- R4: With mode bit0 = 1 (chained), the channel reads four words at the 16-byte-aligned descriptor pointer, in this order: host address, device address, byte count, link. It copies that block. If link bit1 is clear, it then continues at the link value with its low 4 bits forced to zero. If link bit1 is set, that descriptor is the last one.
- R5: Descriptor done (bit4) sets at the end of every descriptor. Transfer done (bit3) sets only when the last descriptor ends. Writing one to either bit clears it; writing zero leaves it unchanged.
- R6: `irq` is high while transfer done is set and mode bit1 is one, or while descriptor done is set and the descriptor that set it had link bit2 set. It stays high until software clears the status bit.
- R7: Writing control/status bit2 while active stops the transfer at the next bus handshake. It clears enable and active, does not set transfer done, does not raise `irq`, and leaves no request on either port.
- R8: Writes to the address, count, pointer and mode registers are ignored while a transfer is active.
- R9: Descriptor pointer bit3 reads back the current direction (mode bit2). The other bits read back the pointer.
- R10: A request is held with a stable address until it is acknowledged. The memory and device ports are never requested in the same cycle.
- R11: A block with a zero byte count moves no data and still sets descriptor done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Host memory request |
| mem_we | output | 1 | Host memory write (0 = read) |
| mem_addr | output | 32 | Host byte address |
| mem_wdata | output | 32 | Host write data |
| mem_ack | input | 1 | Host acknowledge, read data valid |
| mem_rdata | input | 32 | Host read data |
| dev_req | output | 1 | Device request |
| dev_we | output | 1 | Device write (0 = read) |
| dev_addr | output | 32 | Device byte address |
| dev_wdata | output | 32 | Device write data |
| dev_ack | input | 1 | Device acknowledge, read data valid |
| dev_rdata | input | 32 | Device read data |
| irq | output | 1 | Level interrupt |

## Verification
Some properties are checked on every cycle by assertions:
- request hold and the exclusivity of the two ports;
- a start only following a start write;
- transfer done rising only as the channel goes idle;
- write-one-to-clear stickiness of the status and of `irq`;
- an abort finishing with enable clear and no transfer done.

Other behaviour can only be shown by the bench scenarios, because it concerns what lands in the memories and the register values at the end:
- the data actually moved in both directions and for every block length from zero to five words;
- chains of one to three descriptors with flag bits in their link words;
- the per-descriptor interrupt;
- the final address, count and pointer values;
- configuration writes being ignored during a transfer.

// File: rtl/dma_chain_ch.sv
module dma_chain_ch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        dev_req,
  output logic        dev_we,
  output logic [31:0] dev_addr,
  output logic [31:0] dev_wdata,
  input  logic        dev_ack,
  input  logic [31:0] dev_rdata,
  output logic        irq
);
  localparam logic [4:0] A_HADDR = 5'h00;
  localparam logic [4:0] A_DADDR = 5'h04;
  localparam logic [4:0] A_COUNT = 5'h08;
  localparam logic [4:0] A_DPTR  = 5'h0C;
  localparam logic [4:0] A_MODE  = 5'h10;
  localparam logic [4:0] A_CSR   = 5'h14;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_END} st_t;
  st_t st;

  logic [31:0] haddr_q, daddr_q, bcnt_q, dbuf_q;
  logic [27:0] dp_hi_q, lnk_next_q;
  logic [2:0]  dp_lo_q, mode_q;
  logic [1:0]  idx_q;
  logic        lnk_eoc_q, lnk_ie_q;
  logic        de_q, act_q, td_q, dd_q, ddie_q, abt_q;

  wire chain   = mode_q[0];
  wire tdie    = mode_q[1];
  wire to_dev  = mode_q[2];
  wire csr_wr  = reg_we && reg_addr == A_CSR;
  wire cfg_wr  = reg_we && !act_q;
  wire copy_rd = st == S_RD && bcnt_q != 32'd0;
  wire wr_ph   = st == S_WR;
  wire src_ack = to_dev ? mem_ack : dev_ack;
  wire dst_ack = to_dev ? dev_ack : mem_ack;
  wire [31:0] src_data = to_dev ? mem_rdata : dev_rdata;

  assign mem_req   = st == S_FETCH || (to_dev ? copy_rd : wr_ph);
  assign mem_we    = wr_ph && !to_dev;
  assign mem_addr  = st == S_FETCH ? {dp_hi_q, idx_q, 2'b00} : haddr_q;
  assign mem_wdata = dbuf_q;
  assign dev_req   = to_dev ? wr_ph : copy_rd;
  assign dev_we    = wr_ph && to_dev;
  assign dev_addr  = daddr_q;
  assign dev_wdata = dbuf_q;
  assign irq       = (td_q && tdie) || (dd_q && ddie_q);

  always_comb begin
    case (reg_addr)
      A_HADDR: reg_rdata = haddr_q;
      A_DADDR: reg_rdata = daddr_q;
      A_COUNT: reg_rdata = bcnt_q;
      A_DPTR:  reg_rdata = {dp_hi_q, to_dev, dp_lo_q};
      A_MODE:  reg_rdata = {29'd0, mode_q};
      A_CSR:   reg_rdata = {27'd0, dd_q, td_q, 1'b0, act_q, de_q};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      haddr_q <= '0; daddr_q <= '0; bcnt_q <= '0; dbuf_q <= '0;
      dp_hi_q <= '0; dp_lo_q <= '0; mode_q <= '0; idx_q <= '0;
      lnk_next_q <= '0; lnk_eoc_q <= 1'b0; lnk_ie_q <= 1'b0;
      de_q <= 1'b0; act_q <= 1'b0; td_q <= 1'b0; dd_q <= 1'b0;
      ddie_q <= 1'b0; abt_q <= 1'b0;
    end else begin
      if (cfg_wr) begin
        case (reg_addr)
          A_HADDR: haddr_q <= reg_wdata;
          A_DADDR: daddr_q <= reg_wdata;
          A_COUNT: bcnt_q  <= reg_wdata;
          A_DPTR:  begin dp_hi_q <= reg_wdata[31:4]; dp_lo_q <= reg_wdata[2:0]; end
          A_MODE:  mode_q  <= reg_wdata[2:0];
          default: ;
        endcase
      end
      if (csr_wr) begin
        if (reg_wdata[3]) td_q <= 1'b0;
        if (reg_wdata[4]) begin dd_q <= 1'b0; ddie_q <= 1'b0; end
        if (reg_wdata[2]) begin
          if (act_q) abt_q <= 1'b1;
          else       de_q  <= 1'b0;
        end else if (!act_q) begin
          de_q <= reg_wdata[0];
          if (reg_wdata[1:0] == 2'b11) begin
            act_q     <= 1'b1;
            abt_q     <= 1'b0;
            idx_q     <= 2'd0;
            lnk_eoc_q <= 1'b1;
            lnk_ie_q  <= 1'b0;
            st        <= chain ? S_FETCH : S_RD;
          end
        end
      end
      case (st)
        S_FETCH: if (mem_ack) begin
          case (idx_q)
            2'd0: haddr_q <= mem_rdata;
            2'd1: daddr_q <= mem_rdata;
            2'd2: bcnt_q  <= mem_rdata;
            default: begin
              lnk_next_q <= mem_rdata[31:4];
              lnk_eoc_q  <= mem_rdata[1];
              lnk_ie_q   <= mem_rdata[2];
            end
          endcase
          idx_q <= idx_q + 2'd1;
          if (abt_q) begin
            st <= S_IDLE; act_q <= 1'b0; de_q <= 1'b0; abt_q <= 1'b0;
          end else if (idx_q == 2'd3) st <= S_RD;
        end
        S_RD: begin
          if (bcnt_q == 32'd0) st <= S_END;
          else if (src_ack) begin
            dbuf_q <= src_data;
            if (abt_q) begin
              st <= S_IDLE; act_q <= 1'b0; de_q <= 1'b0; abt_q <= 1'b0;
            end else st <= S_WR;
          end
        end
        S_WR: if (dst_ack) begin
          haddr_q <= haddr_q + 32'd4;
          daddr_q <= daddr_q + 32'd4;
          bcnt_q  <= bcnt_q > 32'd4 ? bcnt_q - 32'd4 : 32'd0;
          if (abt_q) begin
            st <= S_IDLE; act_q <= 1'b0; de_q <= 1'b0; abt_q <= 1'b0;
          end else st <= S_RD;
        end
        S_END: begin
          dd_q <= 1'b1;
          if (lnk_ie_q) ddie_q <= 1'b1;
          if (abt_q) begin
            st <= S_IDLE; act_q <= 1'b0; de_q <= 1'b0; abt_q <= 1'b0;
          end else if (chain && !lnk_eoc_q) begin
            dp_hi_q <= lnk_next_q;
            dp_lo_q <= 3'd0;
            idx_q   <= 2'd0;
            st      <= S_FETCH;
          end else begin
            td_q  <= 1'b1;
            act_q <= 1'b0;
            abt_q <= 1'b0;
            st    <= S_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_chain_ch_chk.sv
module dma_chain_ch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_we,
  input logic [4:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        dev_req,
  input logic        dev_ack,
  input logic [31:0] dev_addr,
  input logic        irq,
  input logic        act,
  input logic        td,
  input logic        abt,
  input logic        de
);
  wire csr_w = reg_we && reg_addr == 5'h14;

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n) !(mem_req && dev_req)); // R10
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10
  AST_DEV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) dev_req && !dev_ack |=> dev_req && $stable(dev_addr)); // R10
  AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(act) |-> $past(csr_w && reg_wdata[1:0] == 2'b11 && !reg_wdata[2])); // R2
  AST_TD_STICKY: assert property (@(posedge clk) disable iff (!rst_n) td && !(csr_w && reg_wdata[3]) |=> td); // R5
  AST_TD_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(td) |-> $fell(act)); // R5
  AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n) $fell(act) && $past(abt) |-> !de && !$rose(td)); // R7
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) irq && !(csr_w && (reg_wdata[3] || reg_wdata[4])) && !(reg_we && reg_addr == 5'h10) |=> irq); // R6
endmodule

bind dma_chain_ch dma_chain_ch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .dev_req(dev_req), .dev_ack(dev_ack), .dev_addr(dev_addr), .irq(irq),
  .act(act_q), .td(td_q), .abt(abt_q), .de(de_q)
);

// File: tb/dma_chain_ch_tb.sv
module dma_chain_ch_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, dev_req, dev_we, irq;
  logic [31:0] mem_addr, mem_wdata, dev_addr, dev_wdata;
  logic        m_ack = 1'b0, d_ack = 1'b0;
  logic [31:0] m_rdata = '0, d_rdata = '0;

  dma_chain_ch u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(m_ack), .mem_rdata(m_rdata), .dev_req(dev_req),
    .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_ack(d_ack),
    .dev_rdata(d_rdata), .irq(irq)
  );

  logic [31:0] hmem [256];
  logic [31:0] dmem [256];
  int lat = 0;
  int m_cnt = 0, d_cnt = 0;
  logic bk_we = 1'b0, bk_sel = 1'b0;
  logic [7:0] bk_addr = '0;
  logic [31:0] bk_data = '0;
  int checks = 0, fails = 0;
  logic both_seen = 1'b0, hold_bad = 1'b0;
  logic p_mreq = 1'b0, p_mack = 1'b0;
  logic [31:0] p_maddr = '0;

  always @(posedge clk) begin
    m_ack <= 1'b0;
    d_ack <= 1'b0;
    if (bk_we) begin
      if (bk_sel) dmem[bk_addr] <= bk_data;
      else        hmem[bk_addr] <= bk_data;
    end
    if (mem_req && !m_ack) begin
      if (m_cnt >= lat) begin
        m_ack <= 1'b1; m_cnt <= 0;
        m_rdata <= hmem[mem_addr[9:2]];
        if (mem_we) hmem[mem_addr[9:2]] <= mem_wdata;
      end else m_cnt <= m_cnt + 1;
    end
    if (dev_req && !d_ack) begin
      if (d_cnt >= lat) begin
        d_ack <= 1'b1; d_cnt <= 0;
        d_rdata <= dmem[dev_addr[9:2]];
        if (dev_we) dmem[dev_addr[9:2]] <= dev_wdata;
      end else d_cnt <= d_cnt + 1;
    end
    if (rst_n) begin
      if (mem_req && dev_req) both_seen <= 1'b1;
      if (p_mreq && !p_mack && (!mem_req || mem_addr != p_maddr)) hold_bad <= 1'b1;
    end
    p_mreq <= mem_req; p_mack <= m_ack; p_maddr <= mem_addr;
  end

  task automatic chk(input bit ok, input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, a, e);
    end
  endtask

  task automatic eq(input string r, input logic [31:0] a, input logic [31:0] e);
    chk(a === e, r, a, e);
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic poke(input logic sel, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bk_we = 1'b1; bk_sel = sel; bk_addr = a; bk_data = d;
    @(negedge clk); bk_we = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int t = 0;
    do begin @(negedge clk); rreg(5'h14, v); t++; end while (v[1] && t < 20000);
  endtask

  function automatic logic [31:0] pat(input int a, input int b, input int c, input int i);
    return 32'hA500_0000 ^ (a << 20) ^ (b << 12) ^ (c << 8) ^ i;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rreg(5'(a * 4), v);
      eq("R1 register reset", v, 32'd0);
    end
    eq("R1 irq/req reset", {29'd0, irq, mem_req, dev_req}, 32'd0);
    wreg(5'h14, 32'h2);
    rreg(5'h14, v);
    eq("R2 start without enable ignored", v, 32'd0);

    // single-block sweep
    for (int dir = 0; dir < 2; dir++) begin
      for (int n = 0; n < 6; n++) begin
        for (int i = 0; i <= n; i++) begin
          poke(dir == 0, 8'(dir ? 8'h40 + i : 8'h10 + i), pat(dir, n, 0, i));
          poke(dir != 0, 8'(dir ? 8'h10 + i : 8'h40 + i), 32'hDEAD_0000 | i);
        end
        wreg(5'h10, {29'd0, dir[0], 2'b10});
        wreg(5'h00, 32'h100);
        wreg(5'h04, 32'h40);
        wreg(5'h08, 32'(4 * n));
        wreg(5'h14, 32'h3);
        wait_idle();
        for (int i = 0; i < n; i++)
          eq("R3 data moved", dir ? dmem[8'h10 + i] : hmem[8'h40 + i], pat(dir, n, 0, i));
        eq("R3/R11 word past block untouched", dir ? dmem[8'h10 + n] : hmem[8'h40 + n], 32'hDEAD_0000 | n);
        rreg(5'h08, v); eq("R3 count reaches zero", v, 32'd0);
        rreg(5'h00, v); eq("R3 host address advanced", v, 32'h100 + 4 * n);
        rreg(5'h04, v); eq("R3 device address advanced", v, 32'h40 + 4 * n);
        rreg(5'h14, v); eq("R5/R11 status after block", v, 32'h19);
        eq("R6 irq on done", {31'd0, irq}, 32'd1);
        wreg(5'h14, 32'h1);
        rreg(5'h14, v); eq("R5 zero write keeps status", v, 32'h19);
        wreg(5'h14, 32'h18);
        rreg(5'h14, v); eq("R5 write-one clears", v, 32'h0);
        eq("R6 irq drops on clear", {31'd0, irq}, 32'd0);
      end
    end

    // chained sweep
    for (int dir = 0; dir < 2; dir++) begin
      for (int k = 1; k <= 3; k++) begin
        for (int j = 0; j < k; j++) begin
          int c = ((j + k) % 3) + 1;
          logic [31:0] lk;
          lk = (j == k - 1) ? 32'h2 : ((32'h200 + 32'h10 * (j + 1)) | (j == 0 ? 32'h9 : 32'h0));
          poke(0, 8'(8'h80 + 4 * j), 32'h300 + 32'h20 * j);
          poke(0, 8'(8'h81 + 4 * j), 32'h80 + 32'h20 * j);
          poke(0, 8'(8'h82 + 4 * j), 32'(4 * c));
          poke(0, 8'(8'h83 + 4 * j), lk);
          for (int i = 0; i <= c; i++) begin
            poke(dir == 0, 8'(dir ? 8'hC0 + 8 * j + i : 8'h20 + 8 * j + i), pat(dir, k, j, i));
            poke(dir != 0, 8'(dir ? 8'h20 + 8 * j + i : 8'hC0 + 8 * j + i), 32'hBEEF_0000 | i);
          end
        end
        wreg(5'h10, {29'd0, dir[0], 2'b11});
        wreg(5'h0C, 32'h200);
        wreg(5'h14, 32'h3);
        wait_idle();
        for (int j = 0; j < k; j++) begin
          int c = ((j + k) % 3) + 1;
          for (int i = 0; i < c; i++)
            eq("R4 chained data", dir ? dmem[8'h20 + 8 * j + i] : hmem[8'hC0 + 8 * j + i], pat(dir, k, j, i));
          eq("R4 word past descriptor block", dir ? dmem[8'h20 + 8 * j + c] : hmem[8'hC0 + 8 * j + c], 32'hBEEF_0000 | c);
        end
        rreg(5'h14, v); eq("R5 chain status", v, 32'h19);
        rreg(5'h0C, v); eq("R9 pointer readback", v, (32'h200 + 32'h10 * (k - 1)) | (dir << 3));
        eq("R6 irq after chain", {31'd0, irq}, 32'd1);
        wreg(5'h14, 32'h18);
      end
    end

    // per-descriptor interrupt
    poke(0, 8'h80, 32'h300); poke(0, 8'h81, 32'h80); poke(0, 8'h82, 32'h4); poke(0, 8'h83, 32'h6);
    wreg(5'h10, 32'h1); wreg(5'h0C, 32'h200); wreg(5'h14, 32'h3);
    wait_idle();
    eq("R6 descriptor interrupt", {31'd0, irq}, 32'd1);
    wreg(5'h14, 32'h10);
    rreg(5'h14, v); eq("R5 descriptor-done cleared alone", v, 32'h08);
    eq("R6 irq gone, done irq disabled", {31'd0, irq}, 32'd0);
    poke(0, 8'h83, 32'h2);
    wreg(5'h14, 32'h3);
    wait_idle();
    eq("R6 no irq without enables", {31'd0, irq}, 32'd0);
    wreg(5'h14, 32'h18);

    // abort
    lat = 3;
    wreg(5'h10, 32'h6); wreg(5'h00, 32'h0); wreg(5'h04, 32'h0); wreg(5'h08, 32'd240);
    wreg(5'h14, 32'h3);
    rreg(5'h14, v); eq("R2 active after start", v & 32'h3, 32'h3);
    repeat (30) @(negedge clk);
    wreg(5'h14, 32'h4);
    for (int t = 0; t < 100; t++) begin
      @(negedge clk); rreg(5'h14, v);
      if (!v[0]) break;
    end
    eq("R7 abort status", v & 32'hB, 32'h0);
    eq("R7 no irq on abort", {31'd0, irq}, 32'd0);
    rreg(5'h08, v);
    chk(v != 0 && v < 240, "R7 stopped mid-block", v, 32'd120);
    repeat (20) @(negedge clk);
    eq("R7 ports quiet", {30'd0, mem_req, dev_req}, 32'd0);

    // writes ignored while active
    lat = 2;
    for (int i = 0; i < 9; i++) begin
      poke(1, 8'(8'h10 + i), pat(3, 3, 3, i));
      poke(0, 8'(8'h40 + i), 32'hC0DE_0000 | i);
    end
    wreg(5'h10, 32'h2); wreg(5'h00, 32'h100); wreg(5'h04, 32'h40); wreg(5'h08, 32'd32);
    wreg(5'h14, 32'h3);
    repeat (5) @(negedge clk);
    wreg(5'h08, 32'h400); wreg(5'h00, 32'h0); wreg(5'h10, 32'h0);
    wait_idle();
    rreg(5'h08, v); eq("R8 count write ignored", v, 32'd0);
    rreg(5'h00, v); eq("R8 address write ignored", v, 32'h120);
    rreg(5'h10, v); eq("R8 mode write ignored", v, 32'h2);
    eq("R8 last word moved", hmem[8'h47], pat(3, 3, 3, 7));
    eq("R8 no extra word", hmem[8'h48], 32'hC0DE_0008);
    wreg(5'h14, 32'h18);

    eq("R10 ports never both requested", {31'd0, both_seen}, 32'd0);
    eq("R10 request held until ack", {31'd0, hold_bad}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule